// File: doc/BRIEF.md
# Audio clock regeneration calculator

This block works out the pair of integers that a digital display link sends so that a sink can rebuild its audio sample clock from the link's pixel clock. The first integer (N) sets the audio-side count and the second (CTS) sets the pixel-side count. The caller gives a pixel clock in kHz and picks one of three audio sample rates, then pulses `start`. The block latches both operands and returns N, CTS, two range flags and a one-cycle `done` pulse.

Ten common pixel clocks are held in a small constant table and give their result in the cycle after the operands are latched. Any other clock goes through a sequential fallback. The starting pair is 128 x rate for N and clock x 1000 for CTS. Both are divided by their greatest common divisor, which a binary-GCD engine finds at one step per clock. A multiplier is then chosen as the ceiling of the optimal N (128 x rate / 1000) over the reduced N, and both values are scaled by it. Division and multiplication are serial shift-subtract and shift-add units, so the block contains no wide combinational arithmetic.

A fallback result is flagged when N falls outside the recommended window, and the values are still returned. A zero clock bypasses all arithmetic.

Top module: `acr_calc`

## Requirements
- R1: When the latched pixel clock matches a table entry, `done` is high for the second rising edge after the edge that accepts `start`, and both range flags are 0.
- R2: For table clocks at rate select 0 (32 kHz) the result is N=4096, and at rate select 2 (48 kHz) it is N=6144. In both cases CTS equals the clock in kHz.
- R3: For table clocks at rate select 1 (44.1 kHz) the result is the stored, non-uniform pair. Examples: 25175 kHz gives 28224/125875, 74176 kHz gives 5733/75335, 148352 kHz gives 5733/150670 and 148500 kHz gives 6272/165000.
- R4: For a non-zero clock not in the table, the pair (128 x rate, clock x 1000) is reduced by its greatest common divisor.
- R5: The reduced pair is then multiplied by ceil(floor(128 x rate / 1000) / N_reduced). The resulting N is the smallest multiple of the reduced N that is at least the optimal N.
- R6: On the fallback path, `n_too_large` is set when N > floor(128 x rate / 300) and `n_too_small` is set when N < floor(128 x rate / 1500). N and CTS are returned unchanged in either case.
- R7: A zero pixel clock returns N=0 and CTS=0 with both range flags set, with the same timing as R1.
- R8: A `start` pulse that arrives while `busy` is high is ignored. The result and the number of `done` pulses are those of the request already running.
- R9: `done` lasts exactly one cycle. `busy` is high from the edge that accepts `start` until the edge that raises `done`.
- R10: Rate select encoding: 0 selects 32 kHz, 1 selects 44.1 kHz, 2 selects 48 kHz, and 3 is treated as 48 kHz.
- R11: After reset, `done`, `busy`, N, CTS and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Request pulse; latches `pix_khz` and `fs_sel` when idle |
| pix_khz | input | 18 | Pixel clock in kHz |
| fs_sel | input | 2 | Audio sample rate select (R10 encoding) |
| busy | output | 1 | A request is being processed |
| done | output | 1 | One-cycle pulse: result valid |
| n_out | output | 20 | Resulting N |
| cts_out | output | 28 | Resulting CTS |
| n_too_small | output | 1 | N below the recommended window |
| n_too_large | output | 1 | N above the recommended window |

## Verification
The assertions rely on a few properties of the operands. Both GCD operands are non-zero, which holds because a zero clock never enters the fallback. Every divisor handed to the serial divider is non-zero. The pixel clock fits 18 bits, so clock x 1000 fits the 28-bit datapath. The stimulus keeps within these limits: clocks run from 0 to 262143 kHz, and every one of the four rate-select codes is used. The bench compares results from the constant table and from the fallback path against values worked out by hand and against an independent Euclid-based model.

// File: rtl/acr_pkg.sv
package acr_pkg;

  localparam int unsigned ACR_CLK_W   = 18;
  localparam int unsigned ACR_N_W     = 20;
  localparam int unsigned ACR_CTS_W   = 28;
  localparam int unsigned ACR_MUL_W   = 14;
  localparam int unsigned ACR_TBL_LEN = 10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_GCD,
    ST_RED,
    ST_MULT,
    ST_SCALE
  } acr_state_e;

  // 128 x sample rate; selects 2 and 3 both mean 48 kHz
  function automatic logic [31:0] fs_base_n(input logic [1:0] sel);
    case (sel)
      2'd0:    return 32'd4096000;
      2'd1:    return 32'd5644800;
      default: return 32'd6144000;
    endcase
  endfunction

  // floor(128 x rate / 1000)
  function automatic logic [31:0] fs_opt_n(input logic [1:0] sel);
    case (sel)
      2'd0:    return 32'd4096;
      2'd1:    return 32'd5644;
      default: return 32'd6144;
    endcase
  endfunction

  // floor(128 x rate / 1500)
  function automatic logic [31:0] fs_low_n(input logic [1:0] sel);
    case (sel)
      2'd0:    return 32'd2730;
      2'd1:    return 32'd3763;
      default: return 32'd4096;
    endcase
  endfunction

  // floor(128 x rate / 300)
  function automatic logic [31:0] fs_high_n(input logic [1:0] sel);
    case (sel)
      2'd0:    return 32'd13653;
      2'd1:    return 32'd18816;
      default: return 32'd20480;
    endcase
  endfunction

  function automatic logic [31:0] tbl_clk(input int idx);
    case (idx)
      0:       return 32'd25175;
      1:       return 32'd25200;
      2:       return 32'd27000;
      3:       return 32'd27027;
      4:       return 32'd54000;
      5:       return 32'd54054;
      6:       return 32'd74176;
      7:       return 32'd74250;
      8:       return 32'd148352;
      default: return 32'd148500;
    endcase
  endfunction

  function automatic logic [31:0] tbl_n44(input int idx);
    case (idx)
      0:       return 32'd28224;
      6, 8:    return 32'd5733;
      default: return 32'd6272;
    endcase
  endfunction

  function automatic logic [31:0] tbl_cts44(input int idx);
    case (idx)
      0:       return 32'd125875;
      1:       return 32'd28000;
      2:       return 32'd30000;
      3:       return 32'd30030;
      4:       return 32'd60000;
      5:       return 32'd60060;
      6:       return 32'd75335;
      7:       return 32'd82500;
      8:       return 32'd150670;
      default: return 32'd165000;
    endcase
  endfunction

endpackage

// File: rtl/acr_lookup.sv
module acr_lookup
  import acr_pkg::*;
#(
  parameter int CLK_W = ACR_CLK_W,
  parameter int N_W   = ACR_N_W,
  parameter int CTS_W = ACR_CTS_W
) (
  input  logic [CLK_W-1:0] pix_khz,
  input  logic [1:0]       fs_sel,
  output logic             hit,
  output logic [N_W-1:0]   n_val,
  output logic [CTS_W-1:0] cts_val
);

  localparam int LEN = ACR_TBL_LEN;

  logic [LEN-1:0] match;

  for (genvar i = 0; i < LEN; i++) begin : g_entry
    assign match[i] = (32'(pix_khz) == tbl_clk(i));
  end

  always_comb begin
    hit     = |match;
    n_val   = '0;
    cts_val = '0;
    for (int i = 0; i < LEN; i++) begin
      if (match[i]) begin
        case (fs_sel)
          2'd0: begin
            n_val   = N_W'(32'd4096);
            cts_val = CTS_W'(pix_khz);
          end
          2'd1: begin
            n_val   = N_W'(tbl_n44(i));
            cts_val = CTS_W'(tbl_cts44(i));
          end
          default: begin
            n_val   = N_W'(32'd6144);
            cts_val = CTS_W'(pix_khz);
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/acr_gcd.sv
module acr_gcd #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         done,
  output logic [W-1:0] g
);

  localparam int KW = $clog2(W) + 1;

  logic [W-1:0]  a_q, a_d, b_q, b_d, g_q, g_d;
  logic [KW-1:0] k_q, k_d;
  logic          run_q, run_d, done_q, done_d;

  // binary GCD: strip common twos, drop lone twos, subtract odd pairs
  always_comb begin
    a_d    = a_q;
    b_d    = b_q;
    k_d    = k_q;
    g_d    = g_q;
    run_d  = run_q;
    done_d = 1'b0;
    if (go && !run_q) begin
      a_d   = a_in;
      b_d   = b_in;
      k_d   = '0;
      run_d = 1'b1;
    end else if (run_q) begin
      if (a_q == b_q) begin
        g_d    = a_q << k_q;
        run_d  = 1'b0;
        done_d = 1'b1;
      end else if (!a_q[0] && !b_q[0]) begin
        a_d = a_q >> 1;
        b_d = b_q >> 1;
        k_d = k_q + 1'b1;
      end else if (!a_q[0]) begin
        a_d = a_q >> 1;
      end else if (!b_q[0]) begin
        b_d = b_q >> 1;
      end else if (a_q > b_q) begin
        a_d = a_q - b_q;
      end else begin
        b_d = b_q - a_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      k_q    <= '0;
      g_q    <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      a_q    <= a_d;
      b_q    <= b_d;
      k_q    <= k_d;
      g_q    <= g_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
  assign g    = g_q;

  // R4: operands stay non-zero while reducing (caller never passes zero)
  a_r4_gcd_operands_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (a_q != '0 && b_q != '0));

endmodule

// File: rtl/acr_serdiv.sv
module acr_serdiv #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  output logic         done,
  output logic [W-1:0] quot
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, rem_d, q_q, q_d, dvs_q, dvs_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d, done_q, done_d;
  logic [W:0]    rem_sh;

  // restoring division, one quotient bit per clock
  always_comb begin
    rem_d  = rem_q;
    q_d    = q_q;
    dvs_d  = dvs_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    done_d = 1'b0;
    rem_sh = {rem_q, q_q[W-1]};
    if (go && !run_q) begin
      rem_d = '0;
      q_d   = dvd;
      dvs_d = dvs;
      cnt_d = CW'(W);
      run_d = 1'b1;
    end else if (run_q) begin
      if (rem_sh >= {1'b0, dvs_q}) begin
        rem_d = W'(rem_sh - {1'b0, dvs_q});
        q_d   = {q_q[W-2:0], 1'b1};
      end else begin
        rem_d = W'(rem_sh);
        q_d   = {q_q[W-2:0], 1'b0};
      end
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      q_q    <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      q_q    <= q_d;
      dvs_q  <= dvs_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
  assign quot = q_q;

  // R4: a finished division leaves a remainder below its divisor
  a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (rem_q < dvs_q));

endmodule

// File: rtl/acr_sermul.sv
module acr_sermul #(
  parameter int AW = 28,
  parameter int BW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] a,
  input  logic [BW-1:0] b,
  output logic          done,
  output logic [AW-1:0] p
);

  localparam int CW = $clog2(BW + 1);

  logic [AW-1:0] acc_q, acc_d, mc_q, mc_d;
  logic [BW-1:0] mp_q, mp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d, done_q, done_d;

  // shift-and-add, one multiplier bit per clock
  always_comb begin
    acc_d  = acc_q;
    mc_d   = mc_q;
    mp_d   = mp_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    done_d = 1'b0;
    if (go && !run_q) begin
      acc_d = '0;
      mc_d  = a;
      mp_d  = b;
      cnt_d = CW'(BW);
      run_d = 1'b1;
    end else if (run_q) begin
      if (mp_q[0]) acc_d = acc_q + mc_q;
      mc_d  = mc_q << 1;
      mp_d  = mp_q >> 1;
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      mc_q   <= '0;
      mp_q   <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      mc_q   <= mc_d;
      mp_q   <= mp_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
  assign p    = acc_q;

endmodule

// File: rtl/acr_calc.sv
module acr_calc
  import acr_pkg::*;
#(
  parameter int CLK_W = ACR_CLK_W,
  parameter int N_W   = ACR_N_W,
  parameter int CTS_W = ACR_CTS_W,
  parameter int MUL_W = ACR_MUL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CLK_W-1:0] pix_khz,
  input  logic [1:0]       fs_sel,
  output logic             busy,
  output logic             done,
  output logic [N_W-1:0]   n_out,
  output logic [CTS_W-1:0] cts_out,
  output logic             n_too_small,
  output logic             n_too_large
);

  localparam int WK    = CTS_W;
  localparam int LANES = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  acr_state_e       st_q, st_d;
  logic [CLK_W-1:0] pix_q, pix_d;
  logic [1:0]       fs_q, fs_d;
  logic [N_W-1:0]   n_q, n_d;
  logic [CTS_W-1:0] cts_q, cts_d;
  logic             lo_q, lo_d, hi_q, hi_d, done_q, done_d, fb_q, fb_d;
  logic [WK-1:0]    nr_q, nr_d, ctsr_q, ctsr_d;

  logic [WK-1:0]    n_start, cts_start, pix_w;
  logic             tbl_hit;
  logic [N_W-1:0]   tbl_n;
  logic [CTS_W-1:0] tbl_cts;
  logic             gcd_go, gcd_done;
  logic [WK-1:0]    gcd_val;

  logic [LANES-1:0] div_go, div_done, mul_go, mul_done;
  logic [WK-1:0]    div_dvd  [LANES];
  logic [WK-1:0]    div_dvs  [LANES];
  logic [WK-1:0]    div_quot [LANES];
  logic [WK-1:0]    mul_a    [LANES];
  logic [WK-1:0]    mul_p    [LANES];
  logic [MUL_W-1:0] mul_b;

  // starting pair: 128 x rate and clock x 1000 (1000 = 1024 - 16 - 8)
  assign pix_w     = WK'(pix_q);
  assign n_start   = WK'(fs_base_n(fs_q));
  assign cts_start = (pix_w << 10) - (pix_w << 4) - (pix_w << 3);

  acr_lookup #(.CLK_W(CLK_W), .N_W(N_W), .CTS_W(CTS_W)) u_lookup (
    .pix_khz (pix_q),
    .fs_sel  (fs_q),
    .hit     (tbl_hit),
    .n_val   (tbl_n),
    .cts_val (tbl_cts)
  );

  assign gcd_go = (st_q == ST_CHECK) && (pix_q != '0) && !tbl_hit;

  acr_gcd #(.W(WK)) u_gcd (
    .clk   (clk),
    .rst_n (srst_n),
    .go    (gcd_go),
    .a_in  (n_start),
    .b_in  (cts_start),
    .done  (gcd_done),
    .g     (gcd_val)
  );

  // lane 0 divides N (and later forms the ceiling multiplier); lane 1 divides CTS
  always_comb begin
    div_go[0]  = ((st_q == ST_GCD) && gcd_done) || ((st_q == ST_RED) && div_done[0]);
    div_go[1]  = (st_q == ST_GCD) && gcd_done;
    div_dvd[1] = cts_start;
    div_dvs[1] = gcd_val;
    if (st_q == ST_RED) begin
      div_dvd[0] = WK'(fs_opt_n(fs_q)) + div_quot[0] - 1'b1;
      div_dvs[0] = div_quot[0];
    end else begin
      div_dvd[0] = n_start;
      div_dvs[0] = gcd_val;
    end
  end

  assign mul_b    = div_quot[0][MUL_W-1:0];
  assign mul_a[0] = nr_q;
  assign mul_a[1] = ctsr_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign mul_go[l] = (st_q == ST_MULT) && div_done[0];

    acr_serdiv #(.W(WK)) u_div (
      .clk   (clk),
      .rst_n (srst_n),
      .go    (div_go[l]),
      .dvd   (div_dvd[l]),
      .dvs   (div_dvs[l]),
      .done  (div_done[l]),
      .quot  (div_quot[l])
    );

    acr_sermul #(.AW(WK), .BW(MUL_W)) u_mul (
      .clk   (clk),
      .rst_n (srst_n),
      .go    (mul_go[l]),
      .a     (mul_a[l]),
      .b     (mul_b),
      .done  (mul_done[l]),
      .p     (mul_p[l])
    );
  end

  always_comb begin
    st_d   = st_q;
    pix_d  = pix_q;
    fs_d   = fs_q;
    n_d    = n_q;
    cts_d  = cts_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    fb_d   = fb_q;
    nr_d   = nr_q;
    ctsr_d = ctsr_q;
    done_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          pix_d = pix_khz;
          fs_d  = fs_sel;
          st_d  = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (pix_q == '0) begin
          n_d    = '0;
          cts_d  = '0;
          lo_d   = 1'b1;
          hi_d   = 1'b1;
          fb_d   = 1'b0;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else if (tbl_hit) begin
          n_d    = tbl_n;
          cts_d  = tbl_cts;
          lo_d   = 1'b0;
          hi_d   = 1'b0;
          fb_d   = 1'b0;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          fb_d = 1'b1;
          st_d = ST_GCD;
        end
      end
      ST_GCD: begin
        if (gcd_done) st_d = ST_RED;
      end
      ST_RED: begin
        if (div_done[0] && div_done[1]) begin
          nr_d   = div_quot[0];
          ctsr_d = div_quot[1];
          st_d   = ST_MULT;
        end
      end
      ST_MULT: begin
        if (div_done[0]) st_d = ST_SCALE;
      end
      ST_SCALE: begin
        if (mul_done[0] && mul_done[1]) begin
          n_d    = N_W'(mul_p[0]);
          cts_d  = CTS_W'(mul_p[1]);
          lo_d   = mul_p[0] < WK'(fs_low_n(fs_q));
          hi_d   = mul_p[0] > WK'(fs_high_n(fs_q));
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q   <= ST_IDLE;
      pix_q  <= '0;
      fs_q   <= '0;
      n_q    <= '0;
      cts_q  <= '0;
      lo_q   <= 1'b0;
      hi_q   <= 1'b0;
      fb_q   <= 1'b0;
      nr_q   <= '0;
      ctsr_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pix_q  <= pix_d;
      fs_q   <= fs_d;
      n_q    <= n_d;
      cts_q  <= cts_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      fb_q   <= fb_d;
      nr_q   <= nr_d;
      ctsr_q <= ctsr_d;
      done_q <= done_d;
    end
  end

  assign busy        = (st_q != ST_IDLE);
  assign done        = done_q;
  assign n_out       = n_q;
  assign cts_out     = cts_q;
  assign n_too_small = lo_q;
  assign n_too_large = hi_q;

  // R1: a table hit finishes on the next edge with clear flags
  a_r1_hit_next_cycle: assert property (@(posedge clk) disable iff (!srst_n)
    (st_q == ST_CHECK && tbl_hit && pix_q != '0) |=> (done_q && !lo_q && !hi_q));

  // R5: scaled N reaches the optimal N
  a_r5_n_reaches_opt: assert property (@(posedge clk) disable iff (!srst_n)
    (done_q && fb_q) |-> (32'(n_q) >= fs_opt_n(fs_q)));

  // R7: zero clock result
  a_r7_zero_clock: assert property (@(posedge clk) disable iff (!srst_n)
    (done_q && pix_q == '0) |-> (n_q == '0 && cts_q == '0 && lo_q && hi_q));

  // R8: operands stay put while busy
  a_r8_busy_keeps_operands: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && start) |=> (pix_q == $past(pix_q) && fs_q == $past(fs_q)));

  // R9: done is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!srst_n)
    done_q |=> !done_q);

endmodule

// File: tb/tb_acr_calc.sv
module tb_acr_calc;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [17:0] pix_khz;
  logic [1:0]  fs_sel;
  logic        busy, done, n_too_small, n_too_large;
  logic [19:0] n_out;
  logic [27:0] cts_out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  acr_calc dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .pix_khz     (pix_khz),
    .fs_sel      (fs_sel),
    .busy        (busy),
    .done        (done),
    .n_out       (n_out),
    .cts_out     (cts_out),
    .n_too_small (n_too_small),
    .n_too_large (n_too_large)
  );

  typedef struct packed {
    logic [17:0] pix;
    logic [1:0]  fs;
    logic [19:0] n;
    logic [27:0] cts;
    logic        lo;
    logic        hi;
    logic        hit;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{18'd25175,  2'd0, 20'd4096,  28'd25175,  1'b0, 1'b0, 1'b1}, // R2
    '{18'd148500, 2'd2, 20'd6144,  28'd148500, 1'b0, 1'b0, 1'b1}, // R2
    '{18'd25175,  2'd1, 20'd28224, 28'd125875, 1'b0, 1'b0, 1'b1}, // R3
    '{18'd74176,  2'd1, 20'd5733,  28'd75335,  1'b0, 1'b0, 1'b1}, // R3
    '{18'd148500, 2'd1, 20'd6272,  28'd165000, 1'b0, 1'b0, 1'b1}, // R3
    '{18'd148352, 2'd1, 20'd5733,  28'd150670, 1'b0, 1'b0, 1'b1}, // R3
    '{18'd54054,  2'd3, 20'd6144,  28'd54054,  1'b0, 1'b0, 1'b1}, // R10
    '{18'd100000, 2'd2, 20'd6144,  28'd100000, 1'b0, 1'b0, 1'b0}, // R4 R5
    '{18'd65000,  2'd1, 20'd7056,  28'd81250,  1'b0, 1'b0, 1'b0}, // R5
    '{18'd33000,  2'd0, 20'd4096,  28'd33000,  1'b0, 1'b0, 1'b0}, // R5
    '{18'd1,      2'd0, 20'd4096,  28'd1,      1'b0, 1'b0, 1'b0}, // R4
    '{18'd25177,  2'd1, 20'd28224, 28'd125885, 1'b0, 1'b1, 1'b0}  // R6
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // independent model of the fallback path (Euclid with modulo)
  task automatic ref_fb(input longint unsigned pix, input int fs,
                        output longint unsigned n, output longint unsigned c,
                        output bit lo, output bit hi);
    longint unsigned hz, a, b, t, n0, c0, opt, m;
    hz = (fs == 0) ? 32000 : (fs == 1) ? 44100 : 48000;
    n0 = 128 * hz;
    c0 = pix * 1000;
    a = n0;
    b = c0;
    while (b != 0) begin
      t = a % b;
      a = b;
      b = t;
    end
    n0 = n0 / a;
    c0 = c0 / a;
    opt = 128 * hz / 1000;
    m = (opt + n0 - 1) / n0;
    n = n0 * m;
    c = c0 * m;
    lo = (n < 128 * hz / 1500);
    hi = (n > 128 * hz / 300);
  endtask

  // drive a request; lat counts negedges from the accepting edge to done
  task automatic run_req(input logic [17:0] pix, input logic [1:0] fs, output int lat);
    start   = 1'b1;
    pix_khz = pix;
    fs_sel  = fs;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat   = 1;
    chk(busy == 1'b1, "R9 busy after start", busy, 1);
    while (!done && lat < 3000) begin
      @(negedge clk);
      lat++;
    end
    if (!done) chk(1'b0, "R9 done never rose (watchdog)", 0, 1);
  endtask

  task automatic after_done();
    @(negedge clk);
    chk(done == 1'b0, "R9 done lasts one cycle", done, 0);
    chk(busy == 1'b0, "R9 busy low after done", busy, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat;
    longint unsigned en, ec;
    bit elo, ehi;
    rst_n   = 1'b0;
    start   = 1'b0;
    pix_khz = '0;
    fs_sel  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk(done == 1'b0 && busy == 1'b0, "R11 done/busy after reset", {done, busy}, 0);
    chk(n_out == '0 && cts_out == '0, "R11 N/CTS after reset", n_out, 0);
    chk(!n_too_small && !n_too_large, "R11 flags after reset", {n_too_small, n_too_large}, 0);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      run_req(VECS[i].pix, VECS[i].fs, lat);
      chk(n_out == VECS[i].n, $sformatf("R2/R3/R5 N vec %0d", i), n_out, VECS[i].n);
      chk(cts_out == VECS[i].cts, $sformatf("R4 CTS vec %0d", i), cts_out, VECS[i].cts);
      chk(n_too_small == VECS[i].lo && n_too_large == VECS[i].hi,
          $sformatf("R6 flags vec %0d", i), {n_too_small, n_too_large}, {VECS[i].lo, VECS[i].hi});
      if (VECS[i].hit) chk(lat == 2, $sformatf("R1 hit latency vec %0d", i), lat, 2);
      after_done();
    end

    // fallback against the independent model, all rate codes (R10)
    for (int j = 0; j < 4; j++) begin
      logic [17:0] pc;
      pc = (j == 0) ? 18'd12345 : (j == 1) ? 18'd99991 : (j == 2) ? 18'd262143 : 18'd40000;
      ref_fb(longint'(pc), j, en, ec, elo, ehi);
      run_req(pc, 2'(j), lat);
      chk(n_out == 20'(en), "R5 model N", n_out, en);
      chk(cts_out == 28'(ec), "R4 model CTS", cts_out, ec);
      chk(n_too_small == elo && n_too_large == ehi, "R6 model flags",
          {n_too_small, n_too_large}, {elo, ehi});
      after_done();
    end

    // R7 zero clock
    run_req(18'd0, 2'd1, lat);
    chk(lat == 2, "R7 zero clock latency", lat, 2);
    chk(n_out == '0 && cts_out == '0, "R7 zero clock N/CTS", cts_out, 0);
    chk(n_too_small && n_too_large, "R7 zero clock flags", {n_too_small, n_too_large}, 3);
    after_done();

    // R8 start while busy is ignored
    start   = 1'b1;
    pix_khz = 18'd65000;
    fs_sel  = 2'd1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk(busy == 1'b1, "R8 busy during fallback", busy, 1);
    start   = 1'b1;
    pix_khz = 18'd25200;
    fs_sel  = 2'd0;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 3000) begin
      @(negedge clk);
      lat++;
    end
    chk(n_out == 20'd7056, "R8 N from first request", n_out, 7056);
    chk(cts_out == 28'd81250, "R8 CTS from first request", cts_out, 81250);
    begin
      int extra = 0;
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk(extra == 0, "R8 no second done", extra, 0);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule